// File: doc/BRIEF.md
# Peak-cell derandomizer controller

This block sequences a bank of analogue peak-detect-and-hold cells that sit behind one shared shaper input and feed one shared output towards a slower ADC. An event-detect pulse from the analogue side claims a free cell and puts it in its acquire (write) phase. A peak-found flag closes that phase, and the cell then holds its sample. Only pulses that trigger a cell are ever captured, so no baseline sample reaches the converter.

Held cells are queued by arrival order. When the ADC asks for work and no cell is driving the output, the oldest held cell is switched into its drive-out (read) phase. A registered start strobe and cell index go to the converter in the same cycle. When the ADC reports completion, the cell spends one cycle in a reset state and then becomes free again. Because samples are buffered this way, the conversion rate only has to follow the average event rate, not the instantaneous burst rate. Events that arrive while every cell is occupied are dropped and counted.

Top module: `pkd_top`

## Requirements
- R1: After reset, all cells are free, every write, hold and read enable is 0, adcStart is 0, busy is 0 and ovfCount is 0.
- R2: An evtDetect sampled high while no cell is writing and at least one cell is free puts the lowest-indexed free cell in the write phase at that clock edge (bit i of cellWrite goes high for cell i).
- R3: An evtDetect sampled while a cell is in the write phase has no effect: no cell is claimed and ovfCount does not change.
- R4: A peakFound sampled while a cell is writing moves that cell to hold (cellHold bit set, cellWrite bit cleared) at that edge. A peakFound sampled with no cell writing has no effect.
- R5: When no cell is in the read phase, at least one cell is held and adcReq is sampled high, the oldest held cell enters read at that edge. adcStart is high for exactly that one cycle, and selIdx gives that cell's index in the same cycle.
- R6: Held cells are read in the order their write phases ended, whatever their indices.
- R7: At most one cell is in the read phase at a time. A reading cell stays there until adcDone is sampled, and adcReq during a read starts nothing.
- R8: An adcDone sampled while a cell reads takes that cell out of read at that edge into a one-cycle reset state with all its enables low, and the cell is free in the following cycle.
- R9: busy is 1 exactly when no cell is free. A cell in its reset cycle counts as not free.
- R10: An evtDetect sampled with no cell writing and no cell free is dropped, and ovfCount increments by one, saturating at its all-ones value.
- R11: adcReq with no held cell produces no adcStart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| evtDetect | input | 1 | One-cycle pulse: a new pulse began at the shared input |
| peakFound | input | 1 | Peak reached by the cell currently acquiring |
| adcReq | input | 1 | ADC is ready to accept a new conversion |
| adcDone | input | 1 | ADC finished the current conversion |
| cellWrite | output | NUM_CELLS | Per-cell acquire enable |
| cellHold | output | NUM_CELLS | Per-cell hold enable |
| cellRead | output | NUM_CELLS | Per-cell drive-out enable |
| selIdx | output | IDX_W | Index of the cell routed to the ADC, updated with adcStart |
| adcStart | output | 1 | One-cycle conversion start strobe |
| busy | output | 1 | No cell is free to take a new event |
| ovfCount | output | OVF_W | Saturating count of dropped events |

## Verification
The properties assume that adcDone arrives only while some cell is being read, and that the analogue side raises peakFound only during an acquisition. Under those assumptions the read enables stay one-hot and release is clean. The stimulus drives every input as a one-cycle pulse, or as a level held for a known number of cycles, changed on the falling clock edge. It raises adcDone only after it has seen a start strobe. It also sends events during an acquisition on purpose, and with the bank full, so that the ignore and drop paths run inside those same assumptions.

// File: rtl/pkd_pkg.sv
`timescale 1ns/1ps
package pkd_pkg;

  typedef enum logic [2:0] {
    CELL_FREE  = 3'd0,
    CELL_WRITE = 3'd1,
    CELL_HOLD  = 3'd2,
    CELL_READ  = 3'd3,
    CELL_RESET = 3'd4
  } cellState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic push;  // a write phase closed, queue the cell
    logic pop;   // launch the oldest held cell to the ADC
    logic drop;  // event lost, bank full
  } pkdStrobe_t;

endpackage

// File: rtl/pkd_ctrl.sv
`timescale 1ns/1ps
module pkd_ctrl
  import pkd_pkg::*;
#(
  parameter int NUM_CELLS = 4,
  parameter int IDX_W     = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 evtDetect,
  input  logic                 peakFound,
  input  logic                 adcReq,
  input  logic                 adcDone,
  input  logic                 qEmpty,
  input  logic [IDX_W-1:0]     qHead,
  output pkdStrobe_t           strobe,
  output logic [IDX_W-1:0]     pushIdx,
  output logic [NUM_CELLS-1:0] cellWrite,
  output logic [NUM_CELLS-1:0] cellHold,
  output logic [NUM_CELLS-1:0] cellRead,
  output logic                 busy
);

  cellState_e cellState [NUM_CELLS];

  logic [NUM_CELLS-1:0] freeVec;
  logic                 writeActive;
  logic                 readActive;
  logic                 allocHit;
  logic [IDX_W-1:0]     allocIdx;
  logic [IDX_W-1:0]     writeIdx;
  logic                 accept;

  always_comb begin
    for (int i = 0; i < NUM_CELLS; i++) begin
      freeVec[i]   = (cellState[i] == CELL_FREE);
      cellWrite[i] = (cellState[i] == CELL_WRITE);
      cellHold[i]  = (cellState[i] == CELL_HOLD);
      cellRead[i]  = (cellState[i] == CELL_READ);
    end
  end

  // fixed priority: scan downwards so the lowest index wins
  always_comb begin
    allocHit = 1'b0;
    allocIdx = '0;
    writeIdx = '0;
    for (int i = NUM_CELLS - 1; i >= 0; i--) begin
      if (freeVec[i]) begin
        allocHit = 1'b1;
        allocIdx = IDX_W'(i);
      end
      if (cellWrite[i]) writeIdx = IDX_W'(i);
    end
  end

  assign writeActive = |cellWrite;
  assign readActive  = |cellRead;
  assign accept      = evtDetect && !writeActive && allocHit;
  assign busy        = !allocHit;
  assign pushIdx     = writeIdx;

  always_comb begin
    strobe      = '0;
    strobe.push = writeActive && peakFound;
    strobe.pop  = !readActive && !qEmpty && adcReq;
    strobe.drop = evtDetect && !writeActive && !allocHit;
  end

  for (genvar g = 0; g < NUM_CELLS; g++) begin : gCell
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cellState[g] <= CELL_FREE;
      end else begin
        unique case (cellState[g])
          CELL_FREE:  if (accept && allocIdx == MY_IDX) cellState[g] <= CELL_WRITE;
          CELL_WRITE: if (peakFound) cellState[g] <= CELL_HOLD;
          CELL_HOLD:  if (strobe.pop && qHead == MY_IDX) cellState[g] <= CELL_READ;
          CELL_READ:  if (adcDone) cellState[g] <= CELL_RESET;
          CELL_RESET: cellState[g] <= CELL_FREE;
          default:    cellState[g] <= CELL_FREE;
        endcase
      end
    end
  end

endmodule

// File: rtl/pkd_path.sv
`timescale 1ns/1ps
module pkd_path
  import pkd_pkg::*;
#(
  parameter int NUM_CELLS = 4,
  parameter int IDX_W     = 2,
  parameter int OVF_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  pkdStrobe_t       strobe,
  input  logic [IDX_W-1:0] pushIdx,
  output logic             qEmpty,
  output logic [IDX_W-1:0] qHead,
  output logic             adcStart,
  output logic [IDX_W-1:0] selIdx,
  output logic [OVF_W-1:0] ovfCount
);

  localparam int CNT_W = $clog2(NUM_CELLS + 1);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(NUM_CELLS - 1);

  logic [IDX_W-1:0] queueMem [NUM_CELLS];
  logic [IDX_W-1:0] wrPtr;
  logic [IDX_W-1:0] rdPtr;
  logic [CNT_W-1:0] qCount;

  function automatic logic [IDX_W-1:0] nextSlot(input logic [IDX_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  assign qEmpty = (qCount == '0);
  assign qHead  = queueMem[rdPtr];

  always_ff @(posedge clk) begin
    if (strobe.push) queueMem[wrPtr] <= pushIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      qCount <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextSlot(wrPtr);
      if (strobe.pop)  rdPtr <= nextSlot(rdPtr);
      case ({strobe.push, strobe.pop})
        2'b10:   qCount <= qCount + 1'b1;
        2'b01:   qCount <= qCount - 1'b1;
        default: qCount <= qCount;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      adcStart <= 1'b0;
      selIdx   <= '0;
      ovfCount <= '0;
    end else begin
      adcStart <= strobe.pop;
      if (strobe.pop) selIdx <= qHead;
      if (strobe.drop && ovfCount != '1) ovfCount <= ovfCount + 1'b1;
    end
  end

endmodule

// File: rtl/pkd_top.sv
`timescale 1ns/1ps
module pkd_top
  import pkd_pkg::*;
#(
  parameter int NUM_CELLS = 4,
  parameter int OVF_W     = 8,
  localparam int IDX_W    = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 evtDetect,
  input  logic                 peakFound,
  input  logic                 adcReq,
  input  logic                 adcDone,
  output logic [NUM_CELLS-1:0] cellWrite,
  output logic [NUM_CELLS-1:0] cellHold,
  output logic [NUM_CELLS-1:0] cellRead,
  output logic [IDX_W-1:0]     selIdx,
  output logic                 adcStart,
  output logic                 busy,
  output logic [OVF_W-1:0]     ovfCount
);

  pkdStrobe_t       strobe;
  logic [IDX_W-1:0] pushIdx;
  logic             qEmpty;
  logic [IDX_W-1:0] qHead;

  pkd_ctrl #(.NUM_CELLS(NUM_CELLS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .evtDetect(evtDetect), .peakFound(peakFound),
    .adcReq(adcReq), .adcDone(adcDone),
    .qEmpty(qEmpty), .qHead(qHead),
    .strobe(strobe), .pushIdx(pushIdx),
    .cellWrite(cellWrite), .cellHold(cellHold), .cellRead(cellRead),
    .busy(busy)
  );

  pkd_path #(.NUM_CELLS(NUM_CELLS), .IDX_W(IDX_W), .OVF_W(OVF_W)) u_path (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .pushIdx(pushIdx),
    .qEmpty(qEmpty), .qHead(qHead),
    .adcStart(adcStart), .selIdx(selIdx), .ovfCount(ovfCount)
  );

endmodule

// File: rtl/pkd_checker.sv
`timescale 1ns/1ps
module pkd_checker #(
  parameter int NUM_CELLS = 4,
  parameter int OVF_W     = 8,
  parameter int IDX_W     = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 evtDetect,
  input logic                 peakFound,
  input logic                 adcReq,
  input logic                 adcDone,
  input logic [NUM_CELLS-1:0] cellWrite,
  input logic [NUM_CELLS-1:0] cellHold,
  input logic [NUM_CELLS-1:0] cellRead,
  input logic [IDX_W-1:0]     selIdx,
  input logic                 adcStart,
  input logic                 busy,
  input logic [OVF_W-1:0]     ovfCount
);

  AST_ONE_READER: assert property (@(posedge clk) disable iff (!rstN) $onehot0(cellRead)); // R7
  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rstN) $onehot0(cellWrite)); // R3
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN) adcStart |=> !adcStart); // R5
  AST_START_SEL: assert property (@(posedge clk) disable iff (!rstN) adcStart |-> cellRead[selIdx]); // R5
  AST_ALLOC: assert property (@(posedge clk) disable iff (!rstN)
    evtDetect && !(|cellWrite) && !busy |=> (|cellWrite)); // R2
  AST_OVF_STEP: assert property (@(posedge clk) disable iff (!rstN)
    evtDetect && !(|cellWrite) && busy && (ovfCount != '1) |=> ovfCount == $past(ovfCount) + 1'b1); // R10
  AST_OVF_STABLE: assert property (@(posedge clk) disable iff (!rstN) !evtDetect |=> $stable(ovfCount)); // R10
  AST_IDLE_REQ: assert property (@(posedge clk) disable iff (!rstN)
    adcReq && !(|cellHold) |=> !adcStart); // R11

  for (genvar g = 0; g < NUM_CELLS; g++) begin : gCellChk
    AST_ONE_ROLE: assert property (@(posedge clk) disable iff (!rstN)
      $countones({cellWrite[g], cellHold[g], cellRead[g]}) <= 1); // R8
    AST_WRITE_END: assert property (@(posedge clk) disable iff (!rstN)
      cellWrite[g] && peakFound |=> cellHold[g]); // R4
    AST_READ_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
      $rose(cellRead[g]) |-> adcStart && (selIdx == IDX_W'(g))); // R5
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
      cellRead[g] && adcDone |=> !(cellWrite[g] || cellHold[g] || cellRead[g])); // R8
  end

endmodule

bind pkd_top pkd_checker #(.NUM_CELLS(NUM_CELLS), .OVF_W(OVF_W), .IDX_W(IDX_W)) u_pkd_checker (.*);

// File: tb/pkd_top_bench.sv
`timescale 1ns/1ps
module pkd_top_bench;

  localparam int N = 4;
  localparam int OW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evtDetect = 1'b0, peakFound = 1'b0, adcReq = 1'b0, adcDone = 1'b0;
  logic [N-1:0] cellWrite, cellHold, cellRead;
  logic [1:0]   selIdx;
  logic         adcStart, busy;
  logic [OW-1:0] ovfCount;

  int testsRun = 0;
  int testsFailed = 0;

  always #5 clk = ~clk;

  pkd_top #(.NUM_CELLS(N), .OVF_W(OW)) u_pkd_top (
    .clk(clk), .rstN(rstN), .evtDetect(evtDetect), .peakFound(peakFound),
    .adcReq(adcReq), .adcDone(adcDone), .cellWrite(cellWrite), .cellHold(cellHold),
    .cellRead(cellRead), .selIdx(selIdx), .adcStart(adcStart), .busy(busy),
    .ovfCount(ovfCount)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doEvt();
    @(negedge clk) evtDetect = 1'b1;
    @(negedge clk) evtDetect = 1'b0;
  endtask

  task automatic doPeak();
    @(negedge clk) peakFound = 1'b1;
    @(negedge clk) peakFound = 1'b0;
  endtask

  task automatic doDone();
    @(negedge clk) adcDone = 1'b1;
    @(negedge clk) adcDone = 1'b0;
  endtask

  task automatic launchAndCheck(input int expIdx);
    @(negedge clk) adcReq = 1'b1;
    @(negedge clk) adcReq = 1'b0;
    chk("R6", "start strobe", int'(adcStart), 1);
    chk("R6", "read order index", int'(selIdx), expIdx);
    chk("R6", "read enable", int'(cellRead), 1 << expIdx);
  endtask

  task automatic testReset();
    chk("R1", "cellWrite", int'(cellWrite), 0);
    chk("R1", "cellHold", int'(cellHold), 0);
    chk("R1", "cellRead", int'(cellRead), 0);
    chk("R1", "adcStart", int'(adcStart), 0);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "ovfCount", int'(ovfCount), 0);
  endtask

  task automatic testFill();
    doEvt();
    chk("R2", "first cell writes", int'(cellWrite), 1);
    doEvt();
    chk("R3", "event during write ignored", int'(cellWrite), 1);
    chk("R3", "no drop counted", int'(ovfCount), 0);
    doPeak();
    chk("R4", "cell 0 holds", int'(cellHold), 1);
    chk("R4", "write closed", int'(cellWrite), 0);
    for (int c = 1; c < N; c++) begin
      doEvt();
      chk("R2", "next lowest free writes", int'(cellWrite), 1 << c);
      doPeak();
    end
    chk("R4", "all held", int'(cellHold), 15);
    chk("R9", "busy when full", int'(busy), 1);
    doPeak();
    chk("R4", "stray peak ignored", int'(cellHold), 15);
    doEvt();
    chk("R10", "drop counted", int'(ovfCount), 1);
    chk("R10", "no cell claimed", int'(cellWrite), 0);
  endtask

  task automatic testReadRelease();
    @(negedge clk) adcReq = 1'b1;
    @(negedge clk);
    chk("R5", "start strobe", int'(adcStart), 1);
    chk("R5", "selIdx", int'(selIdx), 0);
    chk("R5", "cell 0 reads", int'(cellRead), 1);
    chk("R5", "others hold", int'(cellHold), 14);
    @(negedge clk);
    chk("R5", "strobe one cycle", int'(adcStart), 0);
    chk("R7", "read persists, single", int'(cellRead), 1);
    @(negedge clk) adcReq = 1'b0;
    chk("R7", "no second start", int'(adcStart), 0);
    doDone();
    chk("R8", "reset cycle enables low", int'(cellRead | cellWrite | (cellHold & 1)), 0);
    chk("R9", "reset cell not free", int'(busy), 1);
    @(negedge clk);
    chk("R8", "cell free after reset", int'(busy), 0);
    doEvt();
    chk("R2", "freed cell 0 reused", int'(cellWrite), 1);
    doPeak();
  endtask

  task automatic testOrder();
    int expOrder[4] = '{1, 2, 3, 0};
    foreach (expOrder[k]) begin
      launchAndCheck(expOrder[k]);
      doDone();
      @(negedge clk);
    end
    chk("R8", "all free at end", int'(busy), 0);
    chk("R6", "nothing held", int'(cellHold), 0);
  endtask

  task automatic testIdleReq();
    @(negedge clk) adcReq = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R11", "no start with empty queue", int'(adcStart), 0);
    end
    adcReq = 1'b0;
  endtask

  task automatic testSaturate();
    for (int c = 0; c < N; c++) begin
      doEvt();
      doPeak();
    end
    doEvt();
    chk("R10", "drop count steps", int'(ovfCount), 2);
    for (int k = 0; k < 300; k++) doEvt();
    chk("R10", "drop count saturates", int'(ovfCount), 255);
    chk("R10", "bank untouched", int'(cellHold), 15);
  endtask

  initial begin
    #(200000 * 10);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFill();
    testReadRelease();
    testOrder();
    testIdleReq();
    testSaturate();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule